// File: doc/BRIEF.md
# Value-Reuse Register Renamer

This block is the rename stage of an out-of-order core. It binds each architectural (logical) register to an entry in a larger pool of physical registers. A rename request names a destination and two sources. In the same cycle the block returns the physical tags that currently hold the sources, along with a newly picked physical tag for the destination. Requests use a valid/ready handshake. The block commits a request only on a cycle where both `ren_valid` and `ren_ready` are high, and a requester that sees `ren_ready` low must hold its request until it is taken.

Result writebacks arrive as a physical tag and a 32-bit value. Writebacks cannot be back-pressured. The block compares each value against every physical register whose value it currently tracks.

- On a miss, the new value is recorded.
- On a hit, every logical register bound to the writer's tag is redirected to the register that already holds the identical value, and the writer's register is released in that same cycle. The block announces both events so that consumers holding the old tag can redirect.

Several logical registers can therefore share one physical register. Each physical register keeps a reference count, and it goes back to the free pool only when nothing maps to it any more.

Top module: `vr_renamer`

## Requirements
- R1: After reset, logical register i reads physical tag i. Physical tags NUM_LREG and above are free. No physical register holds a tracked value.
- R2: A request's source tags are the current bindings, read before that request's own destination update takes effect.
- R3: An accepted request binds its destination to the lowest-numbered free physical tag, which is offered on `ren_dst_ptag`. The binding is visible from the next cycle.
- R4: An accepted request drops one reference from the destination's previous physical register. If that leaves it unreferenced, `free_valid` pulses in the same cycle with `free_ptag` equal to that register, and its tracked value is forgotten.
- R5: A writeback to a live register whose value matches no other tracked register raises neither `remap_valid` nor `free_valid`. Its value becomes available for later matches.
- R6: A writeback to a live register whose value equals a tracked register's value raises `remap_valid` with `remap_from` = written tag and `remap_to` = matching tag. In the same cycle it raises `free_valid` with `free_ptag` = written tag. From the next cycle every logical register that read the written tag reads the matching tag.
- R7: A physical register shared by several logical registers is not freed until the last of them is re-bound.
- R8: `ren_ready` is low while no physical register is free or while `wb_valid` is high. A request offered while `ren_ready` is low changes no binding.
- R9: A writeback to an unreferenced physical tag is ignored: no remap and no free are raised, and its value is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Request will be accepted this cycle |
| ren_dst_lreg | input | LW | Destination logical register |
| ren_srca_lreg | input | LW | First source logical register |
| ren_srcb_lreg | input | LW | Second source logical register |
| ren_srca_ptag | output | PW | Physical tag of first source |
| ren_srcb_ptag | output | PW | Physical tag of second source |
| ren_dst_ptag | output | PW | Physical tag assigned to destination |
| wb_valid | input | 1 | Result writeback present |
| wb_ptag | input | PW | Physical tag being written |
| wb_data | input | DATA_W | Result value |
| remap_valid | output | 1 | Written tag redirected to an identical register |
| remap_from | output | PW | Tag that was redirected |
| remap_to | output | PW | Tag now used in its place |
| free_valid | output | 1 | A physical register was released |
| free_ptag | output | PW | Released physical tag |

## Verification
A wrong reference count shows up at the ports in one of two ways, each within a few requests. A shared register may be announced free while a logical register still reads it, and then be handed out as a new destination tag. Or a register may never come back to the pool, so a later request is offered a higher tag than expected. A stale or missing entry in the value table shows up on the very next writeback carrying that value, as a wrong `remap_valid` or `remap_to`. A bad redirection of the map table shows up on the next request that reads the affected logical register as a source.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {
    WB_NONE   = 2'd0,
    WB_IGNORE = 2'd1,
    WB_RECORD = 2'd2,
    WB_SHARE  = 2'd3
  } wb_kind_e;
endpackage

// File: rtl/vr_lowest_pick.sv
module vr_lowest_pick #(
  parameter int N = 16,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/vr_value_cam.sv
module vr_value_cam #(
  parameter int NUM_ENT = 16,
  parameter int DATA_W  = 32,
  parameter int TW      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] look_data,
  input  logic [TW-1:0]     look_excl,
  output logic              hit,
  output logic [TW-1:0]     hit_tag,
  input  logic              wr_en,
  input  logic [TW-1:0]     wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [TW-1:0]     clr_tag
);
  logic [DATA_W-1:0] val_q [NUM_ENT];
  logic [NUM_ENT-1:0] vld_q;
  logic [NUM_ENT-1:0] match;

  // Parallel compare of every tracked entry against the incoming value
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    assign match[e] = vld_q[e] && (val_q[e] == look_data) && (look_excl != TW'(e));
  end

  // Lowest-numbered matching entry wins
  vr_lowest_pick #(.N(NUM_ENT), .W(TW)) u_hit_pick (
    .req  (match),
    .found(hit),
    .idx  (hit_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < NUM_ENT; e++) val_q[e] <= '0;
    end else begin
      if (wr_en) begin
        vld_q[wr_tag] <= 1'b1;
        val_q[wr_tag] <= wr_data;
      end
      if (clr_en) vld_q[clr_tag] <= 1'b0;
    end
  end

  // R5
  cam_hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (vld_q[hit_tag] && (val_q[hit_tag] == look_data)));

  // R4
  cam_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> !vld_q[$past(clr_tag)]);
endmodule

// File: rtl/vr_renamer.sv
module vr_renamer
  import vr_pkg::*;
#(
  parameter int NUM_LREG = 8,
  parameter int NUM_PREG = 16,
  parameter int DATA_W   = 32,
  localparam int LW = (NUM_LREG > 1) ? $clog2(NUM_LREG) : 1,
  localparam int PW = (NUM_PREG > 1) ? $clog2(NUM_PREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  output logic              ren_ready,
  input  logic [LW-1:0]     ren_dst_lreg,
  input  logic [LW-1:0]     ren_srca_lreg,
  input  logic [LW-1:0]     ren_srcb_lreg,
  output logic [PW-1:0]     ren_srca_ptag,
  output logic [PW-1:0]     ren_srcb_ptag,
  output logic [PW-1:0]     ren_dst_ptag,
  input  logic              wb_valid,
  input  logic [PW-1:0]     wb_ptag,
  input  logic [DATA_W-1:0] wb_data,
  output logic              remap_valid,
  output logic [PW-1:0]     remap_from,
  output logic [PW-1:0]     remap_to,
  output logic              free_valid,
  output logic [PW-1:0]     free_ptag
);
  localparam int CW = $clog2(NUM_LREG + 1);

  logic [PW-1:0] map_q [NUM_LREG];
  logic [CW-1:0] cnt_q [NUM_PREG];

  logic [NUM_PREG-1:0] free_vec;
  logic                alloc_ok;
  logic [PW-1:0]       alloc_tag;
  logic                ren_fire;
  logic [PW-1:0]       old_tag;
  logic                old_dies;
  logic                cam_hit;
  logic [PW-1:0]       cam_tag;
  wb_kind_e            wb_kind;
  logic                wb_share;
  logic                wb_record;

  // Free pool: a register is free exactly when nothing references it
  for (genvar p = 0; p < NUM_PREG; p++) begin : g_free
    assign free_vec[p] = (cnt_q[p] == '0);
  end

  vr_lowest_pick #(.N(NUM_PREG), .W(PW)) u_alloc_pick (
    .req  (free_vec),
    .found(alloc_ok),
    .idx  (alloc_tag)
  );

  vr_value_cam #(.NUM_ENT(NUM_PREG), .DATA_W(DATA_W), .TW(PW)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_data(wb_data),
    .look_excl(wb_ptag),
    .hit      (cam_hit),
    .hit_tag  (cam_tag),
    .wr_en    (wb_record),
    .wr_tag   (wb_ptag),
    .wr_data  (wb_data),
    .clr_en   (free_valid),
    .clr_tag  (free_ptag)
  );

  // Rename handshake: writebacks take the cycle, so at most one release per cycle
  assign ren_ready     = alloc_ok && !wb_valid;
  assign ren_fire      = ren_valid && ren_ready;
  assign ren_srca_ptag = map_q[ren_srca_lreg];
  assign ren_srcb_ptag = map_q[ren_srcb_lreg];
  assign ren_dst_ptag  = alloc_tag;
  assign old_tag       = map_q[ren_dst_lreg];
  assign old_dies      = ren_fire && (cnt_q[old_tag] == CW'(1));

  always_comb begin
    if (!wb_valid)                wb_kind = WB_NONE;
    else if (cnt_q[wb_ptag] == '0) wb_kind = WB_IGNORE;
    else if (cam_hit)             wb_kind = WB_SHARE;
    else                          wb_kind = WB_RECORD;
  end

  assign wb_share    = (wb_kind == WB_SHARE);
  assign wb_record   = (wb_kind == WB_RECORD);
  assign remap_valid = wb_share;
  assign remap_from  = wb_ptag;
  assign remap_to    = cam_tag;
  assign free_valid  = old_dies || wb_share;
  assign free_ptag   = wb_share ? wb_ptag : old_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LREG; l++) map_q[l] <= PW'(l);
      for (int p = 0; p < NUM_PREG; p++) cnt_q[p] <= (p < NUM_LREG) ? CW'(1) : '0;
    end else if (ren_fire) begin
      map_q[ren_dst_lreg] <= alloc_tag;
      cnt_q[old_tag]      <= cnt_q[old_tag] - CW'(1);
      cnt_q[alloc_tag]    <= CW'(1);
    end else if (wb_share) begin
      for (int l = 0; l < NUM_LREG; l++) begin
        if (map_q[l] == wb_ptag) map_q[l] <= cam_tag;
      end
      cnt_q[cam_tag] <= cnt_q[cam_tag] + cnt_q[wb_ptag];
      cnt_q[wb_ptag] <= '0;
    end
  end

  // Reference total: every logical register always holds exactly one reference
  logic [31:0] cnt_sum;
  always_comb begin
    cnt_sum = '0;
    for (int p = 0; p < NUM_PREG; p++) cnt_sum = cnt_sum + 32'(cnt_q[p]);
  end

  // R7
  ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sum == 32'(NUM_LREG));

  // R3
  alloc_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |-> (cnt_q[alloc_tag] == '0));

  // R3
  ren_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |=> (map_q[$past(ren_dst_lreg)] == $past(alloc_tag)));

  // R6
  share_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_share |=> (cnt_q[$past(wb_ptag)] == '0));

  // R4
  free_unref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |=> (cnt_q[$past(free_ptag)] == '0));
endmodule

// File: tb/vr_renamer_tb.sv
module vr_renamer_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Main instance: 8 logical, 16 physical
  logic        ren_valid = 1'b0;
  logic        ren_ready;
  logic [2:0]  ren_dst_lreg = '0, ren_srca_lreg = '0, ren_srcb_lreg = '0;
  logic [3:0]  ren_srca_ptag, ren_srcb_ptag, ren_dst_ptag;
  logic        wb_valid = 1'b0;
  logic [3:0]  wb_ptag = '0;
  logic [31:0] wb_data = '0;
  logic        remap_valid, free_valid;
  logic [3:0]  remap_from, remap_to, free_ptag;

  vr_renamer u_dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_dst_lreg(ren_dst_lreg), .ren_srca_lreg(ren_srca_lreg), .ren_srcb_lreg(ren_srcb_lreg),
    .ren_srca_ptag(ren_srca_ptag), .ren_srcb_ptag(ren_srcb_ptag), .ren_dst_ptag(ren_dst_ptag),
    .wb_valid(wb_valid), .wb_ptag(wb_ptag), .wb_data(wb_data),
    .remap_valid(remap_valid), .remap_from(remap_from), .remap_to(remap_to),
    .free_valid(free_valid), .free_ptag(free_ptag)
  );

  // Tight instance: as many physical as logical registers
  logic        f_ren_valid = 1'b0;
  logic        f_ren_ready;
  logic [1:0]  f_dst = '0, f_srca = '0, f_srcb = '0;
  logic [1:0]  f_srca_ptag, f_srcb_ptag, f_dst_ptag;
  logic        f_wb_valid = 1'b0;
  logic [1:0]  f_wb_ptag = '0;
  logic [31:0] f_wb_data = '0;
  logic        f_remap_valid, f_free_valid;
  logic [1:0]  f_remap_from, f_remap_to, f_free_ptag;

  vr_renamer #(.NUM_LREG(4), .NUM_PREG(4), .DATA_W(32)) u_dut_full (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(f_ren_valid), .ren_ready(f_ren_ready),
    .ren_dst_lreg(f_dst), .ren_srca_lreg(f_srca), .ren_srcb_lreg(f_srcb),
    .ren_srca_ptag(f_srca_ptag), .ren_srcb_ptag(f_srcb_ptag), .ren_dst_ptag(f_dst_ptag),
    .wb_valid(f_wb_valid), .wb_ptag(f_wb_ptag), .wb_data(f_wb_data),
    .remap_valid(f_remap_valid), .remap_from(f_remap_from), .remap_to(f_remap_to),
    .free_valid(f_free_valid), .free_ptag(f_free_ptag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offer a request, check the combinational answer, let it commit
  task automatic do_rename(input int dst, input int a, input int b,
                           input int e_a, input int e_b, input int e_dst,
                           input int e_free, input int e_ftag, input string req);
    ren_dst_lreg = 3'(dst); ren_srca_lreg = 3'(a); ren_srcb_lreg = 3'(b);
    ren_valid = 1'b1;
    #1;
    check(req, "ren_ready", int'(ren_ready), 1);
    check(req, "srca_ptag", int'(ren_srca_ptag), e_a);
    check(req, "srcb_ptag", int'(ren_srcb_ptag), e_b);
    check(req, "dst_ptag", int'(ren_dst_ptag), e_dst);
    check(req, "free_valid", int'(free_valid), e_free);
    if (e_free != 0) check(req, "free_ptag", int'(free_ptag), e_ftag);
    check(req, "remap_valid", int'(remap_valid), 0);
    @(negedge clk);
    ren_valid = 1'b0;
  endtask

  task automatic do_wb(input int tag, input int data, input int e_remap, input int e_to,
                       input string req);
    wb_ptag = 4'(tag); wb_data = 32'(data); wb_valid = 1'b1;
    #1;
    check("R8", "ren_ready during writeback", int'(ren_ready), 0);
    check(req, "remap_valid", int'(remap_valid), e_remap);
    check(req, "free_valid", int'(free_valid), e_remap);
    if (e_remap != 0) begin
      check(req, "remap_from", int'(remap_from), tag);
      check(req, "remap_to", int'(remap_to), e_to);
      check(req, "free_ptag", int'(free_ptag), tag);
    end
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic peek(input int lreg, input int e_tag, input string req);
    ren_valid = 1'b0; ren_srca_lreg = 3'(lreg);
    #1;
    check(req, "binding", int'(ren_srca_ptag), e_tag);
    @(negedge clk);
  endtask

  task automatic t_reset;
    ren_srca_lreg = 3'd3; ren_srcb_lreg = 3'd7;
    #1;
    check("R1", "srca after reset", int'(ren_srca_ptag), 3);
    check("R1", "srcb after reset", int'(ren_srcb_ptag), 7);
    check("R1", "first free tag", int'(ren_dst_ptag), 8);
    check("R1", "ren_ready", int'(ren_ready), 1);
    check("R1", "free_valid idle", int'(free_valid), 0);
    check("R1", "remap_valid idle", int'(remap_valid), 0);
    @(negedge clk);
  endtask

  task automatic t_rename_basic;
    do_rename(1, 1, 2, 1, 2, 8, 1, 1, "R2");
    do_rename(2, 1, 2, 8, 2, 1, 1, 2, "R3");
    peek(1, 8, "R3");
    peek(2, 1, "R3");
  endtask

  task automatic t_share;
    do_wb(8, 32'h1234, 0, 0, "R5");
    do_wb(1, 32'h1234, 1, 8, "R6");
    peek(2, 8, "R6");
    do_rename(1, 2, 1, 8, 8, 1, 0, 0, "R7");
    do_rename(2, 2, 0, 8, 0, 2, 1, 8, "R7");
  endtask

  task automatic t_ignore_and_forget;
    do_wb(8, 32'h55, 0, 0, "R9");
    do_wb(2, 32'h1234, 0, 0, "R4");
    do_wb(1, 32'h55, 0, 0, "R9");
    do_rename(3, 3, 1, 3, 1, 8, 1, 3, "R4");
    do_wb(8, 32'h55, 1, 1, "R5");
    peek(3, 1, "R6");
    do_rename(4, 3, 4, 1, 4, 3, 1, 4, "R3");
  endtask

  task automatic t_full;
    #1;
    check("R8", "ready with empty pool", int'(f_ren_ready), 0);
    f_dst = 2'd3; f_ren_valid = 1'b1;
    @(negedge clk);
    f_ren_valid = 1'b0; f_srca = 2'd3;
    #1;
    check("R8", "held request left binding", int'(f_srca_ptag), 3);
    @(negedge clk);
    f_wb_ptag = 2'd1; f_wb_data = 32'd9; f_wb_valid = 1'b1;
    #1;
    check("R5", "full: first value no remap", int'(f_remap_valid), 0);
    @(negedge clk);
    f_wb_ptag = 2'd2;
    #1;
    check("R6", "full: remap_valid", int'(f_remap_valid), 1);
    check("R6", "full: remap_to", int'(f_remap_to), 1);
    check("R6", "full: free_ptag", int'(f_free_ptag), 2);
    @(negedge clk);
    f_wb_valid = 1'b0; f_dst = 2'd3; f_srca = 2'd2;
    #1;
    check("R8", "ready after release", int'(f_ren_ready), 1);
    check("R3", "full: dst tag", int'(f_dst_ptag), 2);
    check("R6", "full: lreg2 redirected", int'(f_srca_ptag), 1);
    f_ren_valid = 1'b1;
    #1;
    check("R4", "full: old tag freed", int'(f_free_ptag), 3);
    @(negedge clk);
    f_ren_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rename_basic();
    t_share();
    t_ignore_and_forget();
    t_full();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule